// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between an ordinary UART and an infrared transceiver. On the transmit side it samples the UART serial level once per bit cell. A cell that carries a zero produces one short high pulse on the infrared line at the start of the cell. A cell that carries a one leaves the line low. The pulse is either three sixteenths of the bit period long or, in a low-power setting, one period of a separately divided infrared clock. The narrow width never exceeds the three-sixteenths width.

On the receive side, a two-flop synchronizer and a rising-edge detector watch the infrared input. Every detected pulse restarts a local bit cell. The recovered UART level is held low for that whole cell, so back-to-back zero bits appear as one continuous low level. Both sides time their cells from a 16x oversample tick. The tick comes from a programmable divisor: one tick every `baud_div + 1` clocks, so one cell is `16 * (baud_div + 1)` clocks.

Top module: `irsir_codec`

## Requirements
- R1: On the transmit side, a bit cell lasts 16*(baud_div+1) clocks. While `uart_txd` is held low, exactly one pulse rises at the start of each cell, so consecutive pulse rising edges are 16*(baud_div+1) clocks apart.
- R2: With `narrow_sel` = 0, each pulse on `ir_txd` is high for exactly 3*(baud_div+1) clocks.
- R3: With `narrow_sel` = 1, each pulse is high for exactly 2^(irclk_sel+1) clocks, where `irclk_sel` is read as an unsigned value from 0 to 15, provided this is no longer than the width in R2.
- R4: In narrow mode, when 2^(irclk_sel+1) exceeds 3*(baud_div+1), the pulse is cut to 3*(baud_div+1) clocks.
- R5: A cell in which `uart_txd` is 1 produces no pulse, and `ir_txd` stays low.
- R6: While `tx_en` is 0, `ir_txd` is low whatever `uart_txd` does.
- R7: `baud_div`, `narrow_sel` and `irclk_sel` are sampled only at cell boundaries. A change made while a pulse is high leaves that pulse and its cell unchanged and applies from the next cell.
- R8: A rising edge on `ir_rxd` that lasts at least one clock drives `uart_rxd` low for exactly 16*(baud_div+1) clocks.
- R9: Each new receive pulse restarts the receive cell. In loopback, a burst of k zero bits therefore gives one continuous low on `uart_rxd` lasting k*16*(baud_div+1) clocks.
- R10: During and just after reset, `ir_txd` is 0 and `uart_rxd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; 0 forces the infrared output low |
| baud_div | input | DIV_W | Oversample divisor; one tick every baud_div+1 clocks |
| irclk_sel | input | 4 | Infrared clock select; the period is 2^(value+1) clocks |
| narrow_sel | input | 1 | 0: pulse of 3/16 of the bit; 1: pulse of one infrared clock period |
| uart_txd | input | 1 | Serial level from the UART transmitter |
| ir_txd | output | 1 | Active-high pulse to the infrared emitter |
| ir_rxd | input | 1 | Active-high pulse from the infrared detector |
| uart_rxd | output | 1 | Recovered serial level to the UART receiver |

## Verification
The hardest case to reach from the ports is a setting change that lands inside a cell whose pulse is already high. The bench cannot see the cell phase, so it waits for the rising edge of `ir_txd`. In that same cycle it switches the pulse mode in one burst and the divisor in another. It then expects the running pulse to keep its old width and the following pulses to take the new width and, for the divisor, the new spacing. Receive-cell restarts are driven by looping the transmit pulses back into `ir_rxd`: each cell end coincides with the next detected edge, so a missing restart shows up as a broken low run.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  localparam int SEL_W = 4;
  localparam int IRW   = (1 << SEL_W) + 1;

  // infrared clock period in system clocks: 2^(sel+1)
  function automatic logic [IRW-1:0] ir_period(input logic [SEL_W-1:0] sel);
    logic [SEL_W:0] sh;
    sh = {1'b0, sel} + 1'b1;
    return IRW'(1) << sh;
  endfunction
endpackage

// File: rtl/irsir_tick_gen.sv
module irsir_tick_gen #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16,
  localparam int PH_W = $clog2(OVS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick,
  output logic [PH_W-1:0]  phase,
  output logic             cell_end
);
  logic [DIV_W-1:0] cnt, div_q;

  assign tick     = (cnt == div_q);
  assign cell_end = tick && (phase == PH_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
      phase <= PH_W'(OVS - 1);
    end else if (restart) begin
      cnt   <= '0;
      phase <= '0;
      div_q <= div_in;
    end else if (tick) begin
      cnt   <= '0;
      phase <= phase + 1'b1;
      if (cell_end) div_q <= div_in;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/irsir_irclk_gen.sv
module irsir_irclk_gen
  import irsir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic [SEL_W-1:0] sel_in,
  output logic             ir_tick
);
  logic [IRW-1:0] cnt, per_q;

  assign ir_tick = (cnt == per_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      per_q <= ir_period('0);
    end else if (sync) begin
      cnt   <= '0;
      per_q <= ir_period(sel_in);
    end else if (ir_tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/irsir_tx_enc.sv
module irsir_tx_enc #(
  parameter int PH_W       = 4,
  parameter int WIDE_TICKS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cell_end,
  input  logic            tick,
  input  logic [PH_W-1:0] phase,
  input  logic            ir_tick,
  input  logic            txd,
  input  logic            narrow_in,
  output logic            pulse_on,
  output logic            mode_q
);
  logic wide_done, narrow_done;

  assign wide_done   = tick && (phase == PH_W'(WIDE_TICKS - 1));
  assign narrow_done = mode_q && ir_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_on <= 1'b0;
      mode_q   <= 1'b0;
    end else if (cell_end) begin
      pulse_on <= !txd;
      mode_q   <= narrow_in;
    end else if (pulse_on && (wide_done || narrow_done)) begin
      pulse_on <= 1'b0;
    end
  end
endmodule

// File: rtl/irsir_rx_dec.sv
module irsir_rx_dec #(
  parameter int OVS  = 16,
  localparam int PH_W = $clog2(OVS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ir_in,
  input  logic            tick,
  input  logic [PH_W-1:0] phase,
  output logic            rise,
  output logic            zero_q
);
  logic [2:0] sync_q;

  assign rise = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      zero_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ir_in};
      if (rise)
        zero_q <= 1'b1;
      else if (tick && phase == PH_W'(OVS - 1))
        zero_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OVS        = 16,
  parameter int WIDE_TICKS = 3,
  localparam int PH_W      = $clog2(OVS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [SEL_W-1:0] irclk_sel,
  input  logic             narrow_sel,
  input  logic             uart_txd,
  output logic             ir_txd,
  input  logic             ir_rxd,
  output logic             uart_rxd
);
  // named internal events, observed by the bound checker
  logic            tx_tick, tx_cell_end, tx_ir_tick, tx_pulse, tx_mode;
  logic [PH_W-1:0] tx_phase;
  logic            rx_tick, rx_cell_end, rx_rise, rx_zero;
  logic [PH_W-1:0] rx_phase;

  irsir_tick_gen #(.DIV_W(DIV_W), .OVS(OVS)) u_tx_tick (
    .clk(clk), .rst_n(rst_n), .restart(1'b0), .div_in(baud_div),
    .tick(tx_tick), .phase(tx_phase), .cell_end(tx_cell_end)
  );

  irsir_irclk_gen u_irclk (
    .clk(clk), .rst_n(rst_n), .sync(tx_cell_end), .sel_in(irclk_sel),
    .ir_tick(tx_ir_tick)
  );

  irsir_tx_enc #(.PH_W(PH_W), .WIDE_TICKS(WIDE_TICKS)) u_enc (
    .clk(clk), .rst_n(rst_n), .cell_end(tx_cell_end), .tick(tx_tick),
    .phase(tx_phase), .ir_tick(tx_ir_tick), .txd(uart_txd),
    .narrow_in(narrow_sel), .pulse_on(tx_pulse), .mode_q(tx_mode)
  );

  irsir_tick_gen #(.DIV_W(DIV_W), .OVS(OVS)) u_rx_tick (
    .clk(clk), .rst_n(rst_n), .restart(rx_rise), .div_in(baud_div),
    .tick(rx_tick), .phase(rx_phase), .cell_end(rx_cell_end)
  );

  irsir_rx_dec #(.OVS(OVS)) u_dec (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_rxd), .tick(rx_tick),
    .phase(rx_phase), .rise(rx_rise), .zero_q(rx_zero)
  );

  assign ir_txd   = tx_pulse && tx_en;
  assign uart_rxd = !rx_zero;
endmodule

// File: rtl/irsir_codec_chk.sv
module irsir_codec_chk #(
  parameter int PH_W       = 4,
  parameter int WIDE_TICKS = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            uart_txd,
  input logic            uart_rxd,
  input logic            tx_cell_end,
  input logic            tx_pulse,
  input logic            tx_mode,
  input logic [PH_W-1:0] tx_phase,
  input logic            rx_rise,
  input logic            rx_cell_end,
  input logic [PH_W-1:0] rx_phase
);
  // R1
  pulse_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pulse) |-> $past(tx_cell_end));

  // R5
  one_bit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cell_end && uart_txd) |=> !tx_pulse);

  // R4
  width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse |-> (tx_phase < PH_W'(WIDE_TICKS)));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_cell_end |=> $stable(tx_mode));

  // R8
  rx_low_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rise |=> !uart_rxd);

  // R8
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cell_end && !rx_rise) |=> uart_rxd);

  // R9
  rx_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rise |=> (rx_phase == '0));
endmodule

bind irsir_codec irsir_codec_chk #(.PH_W(PH_W), .WIDE_TICKS(WIDE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .uart_txd(uart_txd), .uart_rxd(uart_rxd),
  .tx_cell_end(tx_cell_end), .tx_pulse(tx_pulse), .tx_mode(tx_mode),
  .tx_phase(tx_phase), .rx_rise(rx_rise), .rx_cell_end(rx_cell_end),
  .rx_phase(rx_phase)
);

// File: tb/irsir_codec_tb.sv
module irsir_codec_tb;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n, tx_en, narrow_sel, uart_txd, lb, man_rx;
  logic [DIV_W-1:0] baud_div;
  logic [3:0]       irclk_sel;
  logic             ir_txd, uart_rxd;
  wire              ir_rxd = lb ? ir_txd : man_rx;

  always #10 clk = ~clk;

  irsir_codec u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_div(baud_div),
    .irclk_sel(irclk_sel), .narrow_sel(narrow_sel), .uart_txd(uart_txd),
    .ir_txd(ir_txd), .ir_rxd(ir_rxd), .uart_rxd(uart_rxd)
  );

  int checks = 0, errors = 0, cyc = 0;
  int n_pulses = 0, n_rxlow = 0;
  int wq[$], pq[$], rq[$];
  string wtag[$], rtag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cell_len(input int d);
    return 16 * (d + 1);
  endfunction

  function automatic int wide_w(input int d);
    return 3 * (d + 1);
  endfunction

  function automatic int narrow_w(input int d, input int s);
    int p;
    p = 1 << (s + 1);
    return (p < wide_w(d)) ? p : wide_w(d);
  endfunction

  // scoreboard monitor
  bit tx_prev = 0, rx_prev = 1;
  int rise_t = 0, last_rise = 0, rxfall_t = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (ir_txd && !tx_prev) begin
        rise_t = cyc;
        n_pulses++;
      end
      if (!ir_txd && tx_prev) begin
        if (wq.size() == 0) begin
          check(0, "R5 unexpected pulse", cyc - rise_t, 0);
        end else begin
          int w, p;
          string t;
          w = wq.pop_front(); p = pq.pop_front(); t = wtag.pop_front();
          check(cyc - rise_t == w, t, cyc - rise_t, w);
          if (p != 0) check(rise_t - last_rise == p, "R1 period", rise_t - last_rise, p);
        end
        last_rise = rise_t;
      end
      if (!uart_rxd && rx_prev) begin
        rxfall_t = cyc;
        n_rxlow++;
      end
      if (uart_rxd && !rx_prev) begin
        if (rq.size() == 0) begin
          check(0, "R8 unexpected rx low", cyc - rxfall_t, 0);
        end else begin
          int l;
          string t;
          l = rq.pop_front(); t = rtag.pop_front();
          check(cyc - rxfall_t == l, t, cyc - rxfall_t, l);
        end
      end
    end
    tx_prev = ir_txd;
    rx_prev = uart_rxd;
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_tx_drain();
    while (wq.size() != 0) @(negedge clk);
  endtask

  task automatic wait_rise();
    while (!ir_txd) @(negedge clk);
  endtask

  task automatic run_burst(input int d, input bit nar, input int sel, input int k, input bit use_rx);
    int w;
    string t;
    uart_txd = 1'b1; baud_div = DIV_W'(d); narrow_sel = nar;
    irclk_sel = 4'(sel); lb = use_rx;
    wait_cycles(140);
    w = nar ? narrow_w(d, sel) : wide_w(d);
    t = !nar ? "R2" : ((1 << (sel + 1)) > wide_w(d)) ? "R4" : "R3";
    for (int i = 0; i < k; i++) begin
      wq.push_back(w); pq.push_back(i == 0 ? 0 : cell_len(d)); wtag.push_back(t);
    end
    if (use_rx) begin
      rq.push_back(k * cell_len(d)); rtag.push_back("R9 loopback low run");
    end
    uart_txd = 1'b0;
    wait_tx_drain();
    uart_txd = 1'b1;
    wait_cycles(140);
  endtask

  initial begin
    int p0, r0;
    rst_n = 1'b0; tx_en = 1'b1; baud_div = '0; irclk_sel = '0;
    narrow_sel = 1'b0; uart_txd = 1'b1; lb = 1'b1; man_rx = 1'b0;
    wait_cycles(3);
    // R10 reset values
    check(ir_txd == 1'b0, "R10 ir_txd in reset", ir_txd, 0);
    check(uart_rxd == 1'b1, "R10 uart_rxd in reset", uart_rxd, 1);
    rst_n = 1'b1;
    wait_cycles(1);
    check(ir_txd == 1'b0, "R10 ir_txd after reset", ir_txd, 0);
    check(uart_rxd == 1'b1, "R10 uart_rxd after reset", uart_rxd, 1);

    // R2 wide pulses, R1 spacing
    run_burst(0, 1'b0, 0, 4, 1'b1);
    run_burst(3, 1'b0, 0, 4, 1'b1);
    // R3 narrow pulses
    run_burst(3, 1'b1, 0, 3, 1'b1);
    run_burst(3, 1'b1, 2, 3, 1'b1);
    run_burst(1, 1'b1, 1, 3, 1'b1);
    // R4 narrow width capped
    run_burst(3, 1'b1, 3, 3, 1'b1);
    run_burst(0, 1'b1, 1, 3, 1'b1);

    // R5 idle ones give no pulse
    p0 = n_pulses;
    uart_txd = 1'b1; baud_div = 3;
    wait_cycles(300);
    check(n_pulses == p0, "R5 pulses while idle", n_pulses - p0, 0);

    // R6 transmit disabled
    p0 = n_pulses; r0 = n_rxlow;
    tx_en = 1'b0; lb = 1'b1; uart_txd = 1'b0;
    wait_cycles(300);
    check(n_pulses == p0, "R6 pulses while disabled", n_pulses - p0, 0);
    check(n_rxlow == r0, "R6 rx lows while disabled", n_rxlow - r0, 0);
    uart_txd = 1'b1;
    wait_cycles(140);
    tx_en = 1'b1;

    // R7 mode switched while a wide pulse is high
    uart_txd = 1'b1; baud_div = 3; narrow_sel = 1'b0; irclk_sel = 0; lb = 1'b1;
    wait_cycles(140);
    wq.push_back(wide_w(3)); pq.push_back(0); wtag.push_back("R7 running pulse keeps mode");
    for (int i = 0; i < 3; i++) begin
      wq.push_back(narrow_w(3, 0)); pq.push_back(cell_len(3)); wtag.push_back("R7 next cells narrow");
    end
    rq.push_back(4 * cell_len(3)); rtag.push_back("R9 loopback low run");
    uart_txd = 1'b0;
    wait_rise();
    narrow_sel = 1'b1;
    wait_tx_drain();
    uart_txd = 1'b1;
    wait_cycles(140);

    // R7 divisor changed while a pulse is high
    uart_txd = 1'b1; baud_div = 3; narrow_sel = 1'b0; lb = 1'b0;
    wait_cycles(140);
    wq.push_back(wide_w(3)); pq.push_back(0); wtag.push_back("R7 running pulse keeps divisor");
    wq.push_back(wide_w(1)); pq.push_back(cell_len(3)); wtag.push_back("R7 new divisor width");
    wq.push_back(wide_w(1)); pq.push_back(cell_len(1)); wtag.push_back("R7 new divisor width");
    uart_txd = 1'b0;
    wait_rise();
    baud_div = 1;
    wait_tx_drain();
    uart_txd = 1'b1;
    wait_cycles(140);

    // R8 short pulses on the receive input
    lb = 1'b0; baud_div = 3;
    rq.push_back(cell_len(3)); rtag.push_back("R8 two-clock pulse");
    man_rx = 1'b1; wait_cycles(2); man_rx = 1'b0;
    wait_cycles(140);
    baud_div = 0;
    wait_cycles(20);
    rq.push_back(cell_len(0)); rtag.push_back("R8 one-clock pulse");
    man_rx = 1'b1; wait_cycles(1); man_rx = 1'b0;
    wait_cycles(60);
    check(rq.size() == 0, "R8 missing rx lows", rq.size(), 0);
    check(wq.size() == 0, "R1 missing tx pulses", wq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule